// File: doc/BRIEF.md
# Multi-Speed SCL Timing Generator

This block produces the SCL clock waveform of an I2C controller. It holds three independent pairs of period counts, one pair each for standard, fast (fast and fast-plus share it, differing only in the values written) and high-speed operation. A speed input picks the pair. All counts are in cycles of the block's own clock. For example, at 50 MHz a standard-mode low of 4.7 µs is about 235 cycles, and a high-speed high of 160 ns is 8 cycles. A build-time parameter states whether high speed exists. Without it, a high-speed request runs on the fast pair.

A byte sequencer above this block asks for a start, then asks for one SCL pulse per bit. The block drives SCL low for the selected low count and then releases the line. It waits until the sampled line reads high, so a target can stretch the clock. It then counts the high period and drives SCL low again. A separate programmable count sets how long after each SCL fall the SDA-change strobe fires. Counts below 6 are raised to 6. The timing registers accept writes only while the controller is disabled.

The states are IDLE (line released), PARK (SCL held low between bits), LOW (low period counting), WAIT_HI (line released, waiting for it to read high) and HIGH (high period counting). The transitions are:
- IDLE to PARK on `start_req`.
- PARK to LOW on `step_req`.
- LOW to WAIT_HI when the low count expires.
- WAIT_HI to HIGH when `scl_in` is high.
- HIGH to PARK when the high count expires.
- Any state to IDLE when `enable` is low.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, `scl_drive_low`, `bit_done`, `scl_high_seen` and `sda_hold_strobe` are all 0.
- R2: With `speed_sel`=01 (standard), a `step_req` in PARK drives SCL low for exactly the standard low count. After that, the line is released for the standard high count plus the cycles spent waiting for it to read high (at least one).
- R3: With `speed_sel`=10 or 00, the fast pair sets the low and high periods.
- R4: With `speed_sel`=11 and the high-speed option built in, the high-speed pair sets the periods.
- R5: With `speed_sel`=11 and the high-speed option absent (`HS_PRESENT`=0), the fast pair sets the periods.
- R6: Any effective high or low count below 6, including 0, is used as 6.
- R7: While SCL is released and `scl_in` reads low, the high count does not start. The released time grows by the number of stretched cycles.
- R8: Every entry into PARK, whether from a start or from the end of a bit, is followed by a one-cycle `sda_hold_strobe`. With a programmed hold value H, the strobe comes H cycles after the first PARK cycle.
- R9: `cfg_we` writes the register chosen by `cfg_sel` only while `enable` is 0; writes made while `enable` is 1 are ignored. The `cfg_sel` codes are: 0 standard high, 1 standard low, 2 fast high, 3 fast low, 4 high-speed high, 5 high-speed low, 6 SDA hold.
- R10: When `enable` is low, SCL is released in the next cycle. A `step_req` in IDLE starts no pulse.
- R11: `bit_done` pulses once, in the last high cycle of each bit, and SCL is driven low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enable; low forces IDLE and unlocks config writes |
| cfg_we | input | 1 | Config write strobe |
| cfg_sel | input | 3 | Config register select (codes in R9) |
| cfg_wdata | input | CNT_W | Config write data |
| speed_sel | input | 2 | 01 standard, 10/00 fast, 11 high speed |
| start_req | input | 1 | Take the bus: IDLE to PARK |
| step_req | input | 1 | Produce one SCL pulse from PARK |
| scl_in | input | 1 | Sampled SCL line level |
| scl_drive_low | output | 1 | Open-drain pull-down request for SCL |
| scl_high_seen | output | 1 | Strobe: released line seen high, high count begins |
| bit_done | output | 1 | Strobe: last high cycle of a bit |
| sda_hold_strobe | output | 1 | Strobe: SDA may change now |

## Verification
The bench builds two copies side by side: one with the defaults (`CNT_W`=16, `HS_PRESENT`=1) and one with `HS_PRESENT`=0. Both receive the same stimulus, so the same high-speed request shows the high-speed pair on one copy and the fast fallback on the other. Small counts (6 to 24 cycles) keep every period short enough to count exactly, including the clamp floor. A bench-driven target pull-down on each line reaches the stretch path.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PARK,
        PH_LOW,
        PH_WAIT_HI,
        PH_HIGH
    } phase_t;

    localparam logic [1:0] SPD_STD  = 2'b01;
    localparam logic [1:0] SPD_FAST = 2'b10;
    localparam logic [1:0] SPD_HIGH = 2'b11;

    localparam int SEL_STD_HI  = 0;
    localparam int SEL_STD_LO  = 1;
    localparam int SEL_FAST_HI = 2;
    localparam int SEL_FAST_LO = 3;
    localparam int SEL_HS_HI   = 4;
    localparam int SEL_HS_LO   = 5;
    localparam int SEL_HOLD    = 6;
    localparam int NUM_CFG     = 7;

endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs
    import scl_timing_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int MIN_CNT    = 6,
    parameter bit HS_PRESENT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_sel,
    input  logic [CNT_W-1:0] cfg_wdata,
    input  logic [1:0]       speed_sel,
    output logic [CNT_W-1:0] hi_eff,
    output logic [CNT_W-1:0] lo_eff,
    output logic [CNT_W-1:0] hold_cnt
);
    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_CNT);

    logic [CNT_W-1:0] regs [NUM_CFG];
    logic             use_hs;
    logic             use_std;
    logic [CNT_W-1:0] hi_raw;
    logic [CNT_W-1:0] lo_raw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CFG; i++) begin
                regs[i] <= (i == SEL_HOLD) ? '0 : FLOOR;
            end
        end else if (cfg_we && !enable && (cfg_sel < 3'(NUM_CFG))) begin
            regs[cfg_sel] <= cfg_wdata;
        end
    end

    generate
        if (HS_PRESENT) begin : g_hs
            assign use_hs = (speed_sel == SPD_HIGH);
        end else begin : g_no_hs
            assign use_hs = 1'b0;
        end
    endgenerate

    assign use_std = (speed_sel == SPD_STD);

    always_comb begin
        if (use_hs) begin
            hi_raw = regs[SEL_HS_HI];
            lo_raw = regs[SEL_HS_LO];
        end else if (use_std) begin
            hi_raw = regs[SEL_STD_HI];
            lo_raw = regs[SEL_STD_LO];
        end else begin
            hi_raw = regs[SEL_FAST_HI];
            lo_raw = regs[SEL_FAST_LO];
        end
    end

    assign hi_eff   = (hi_raw < FLOOR) ? FLOOR : hi_raw;
    assign lo_eff   = (lo_raw < FLOOR) ? FLOOR : lo_raw;
    assign hold_cnt = regs[SEL_HOLD];

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_timing_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             start_req,
    input  logic             step_req,
    input  logic             scl_in,
    input  logic [CNT_W-1:0] hi_eff,
    input  logic [CNT_W-1:0] lo_eff,
    output phase_t           phase,
    output logic             scl_drive_low,
    output logic             scl_high_seen,
    output logic             bit_done,
    output logic             park_entry
);
    phase_t           st;
    phase_t           nxt;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        nxt = st;
        unique case (st)
            PH_IDLE:    if (start_req)      nxt = PH_PARK;
            PH_PARK:    if (step_req)       nxt = PH_LOW;
            PH_LOW:     if (cnt == '0)      nxt = PH_WAIT_HI;
            PH_WAIT_HI: if (scl_in)         nxt = PH_HIGH;
            PH_HIGH:    if (cnt == '0)      nxt = PH_PARK;
            default:                        nxt = PH_IDLE;
        endcase
        if (!enable) nxt = PH_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= PH_IDLE;
            cnt <= '0;
        end else begin
            st <= nxt;
            if (nxt != st) begin
                if (nxt == PH_LOW)       cnt <= lo_eff - 1'b1;
                else if (nxt == PH_HIGH) cnt <= hi_eff - 1'b1;
                else                     cnt <= '0;
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    always_comb begin
        scl_drive_low = 1'b0;
        scl_high_seen = 1'b0;
        bit_done      = 1'b0;
        unique case (st)
            PH_IDLE:    ;
            PH_PARK:    scl_drive_low = 1'b1;
            PH_LOW:     scl_drive_low = 1'b1;
            PH_WAIT_HI: scl_high_seen = scl_in && enable;
            PH_HIGH:    bit_done      = (cnt == '0);
            default:    ;
        endcase
    end

    assign park_entry = (nxt == PH_PARK) && (st != PH_PARK);
    assign phase      = st;

endmodule

// File: rtl/sda_hold_timer.sv
module sda_hold_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             trigger,
    input  logic [CNT_W-1:0] hold_cnt,
    output logic             strobe
);
    logic             active;
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            remain <= '0;
        end else if (!enable) begin
            active <= 1'b0;
            remain <= '0;
        end else if (trigger) begin
            active <= 1'b1;
            remain <= hold_cnt;
        end else if (active) begin
            if (remain == '0) active <= 1'b0;
            else              remain <= remain - 1'b1;
        end
    end

    assign strobe = active && (remain == '0);

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_timing_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int MIN_CNT    = 6,
    parameter bit HS_PRESENT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_sel,
    input  logic [CNT_W-1:0] cfg_wdata,
    input  logic [1:0]       speed_sel,
    input  logic             start_req,
    input  logic             step_req,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             scl_high_seen,
    output logic             bit_done,
    output logic             sda_hold_strobe
);
    logic [CNT_W-1:0] hi_eff;
    logic [CNT_W-1:0] lo_eff;
    logic [CNT_W-1:0] hold_cnt;
    logic             park_entry;
    phase_t           phase;

    scl_cfg_regs #(
        .CNT_W(CNT_W), .MIN_CNT(MIN_CNT), .HS_PRESENT(HS_PRESENT)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .speed_sel(speed_sel),
        .hi_eff(hi_eff), .lo_eff(lo_eff), .hold_cnt(hold_cnt)
    );

    scl_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .start_req(start_req), .step_req(step_req), .scl_in(scl_in),
        .hi_eff(hi_eff), .lo_eff(lo_eff),
        .phase(phase), .scl_drive_low(scl_drive_low),
        .scl_high_seen(scl_high_seen), .bit_done(bit_done),
        .park_entry(park_entry)
    );

    sda_hold_timer #(.CNT_W(CNT_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .trigger(park_entry), .hold_cnt(hold_cnt),
        .strobe(sda_hold_strobe)
    );

endmodule

// File: rtl/scl_timing_chk.sv
module scl_timing_chk
    import scl_timing_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             scl_in,
    input logic             scl_drive_low,
    input logic             bit_done,
    input phase_t           phase,
    input logic [CNT_W-1:0] hi_eff,
    input logic [CNT_W-1:0] lo_eff,
    input logic [1:0]       speed_sel
);
    AST_RELEASE_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !scl_drive_low); // R10

    AST_STRETCH_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WAIT_HI && !scl_in) |=> (phase == PH_WAIT_HI || phase == PH_IDLE)); // R7

    AST_FALL_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_done && enable) |=> scl_drive_low); // R11

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && $stable(speed_sel)) |-> ($stable(hi_eff) && $stable(lo_eff))); // R9

    AST_FLOOR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LOW) |-> (lo_eff >= CNT_W'(6))); // R6

endmodule

bind scl_timing_gen scl_timing_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .scl_in(scl_in),
    .scl_drive_low(scl_drive_low), .bit_done(bit_done), .phase(phase),
    .hi_eff(hi_eff), .lo_eff(lo_eff), .speed_sel(speed_sel)
);

// File: tb/test_scl_timing_gen.sv
module test_scl_timing_gen;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_sel = '0;
    logic [CW-1:0] cfg_wdata = '0;
    logic [1:0]    speed_sel = 2'b01;
    logic          start_req = 1'b0;
    logic          step_req = 1'b0;
    logic          tgt_hold = 1'b0;

    logic drv_a, seen_a, done_a, hold_a, scl_a;
    logic drv_b, seen_b, done_b, hold_b, scl_b;

    int checks = 0;
    int fails  = 0;
    int done_cnt;

    assign scl_a = ~drv_a & ~tgt_hold;
    assign scl_b = ~drv_b & ~tgt_hold;

    always #10 clk = ~clk;

    scl_timing_gen #(.CNT_W(CW), .HS_PRESENT(1'b1)) i_scl_timing_gen (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .speed_sel(speed_sel),
        .start_req(start_req), .step_req(step_req), .scl_in(scl_a),
        .scl_drive_low(drv_a), .scl_high_seen(seen_a), .bit_done(done_a),
        .sda_hold_strobe(hold_a)
    );

    scl_timing_gen #(.CNT_W(CW), .HS_PRESENT(1'b0)) i_scl_timing_gen_nohs (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .speed_sel(speed_sel),
        .start_req(start_req), .step_req(step_req), .scl_in(scl_b),
        .scl_drive_low(drv_b), .scl_high_seen(seen_b), .bit_done(done_b),
        .sda_hold_strobe(hold_b)
    );

    always @(posedge clk) if (done_a) done_cnt++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int sel, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = CW'(val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic prep(input logic [1:0] spd);
        @(negedge clk);
        enable = 1'b0;
        speed_sel = spd;
        @(negedge clk);
        enable = 1'b1;
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    // one bit pulse; counts low and released cycles on the chosen copy
    task automatic bit_pulse(input bit alt, input int stretch, output int lo_n, output int hi_n);
        lo_n = 0; hi_n = 0;
        if (stretch > 0) tgt_hold = 1'b1;
        @(negedge clk);
        step_req = 1'b1;
        @(negedge clk);
        step_req = 1'b0;
        while ((alt ? drv_b : drv_a) && lo_n < 1000) begin
            lo_n++;
            @(negedge clk);
        end
        while (!(alt ? drv_b : drv_a) && hi_n < 1000) begin
            hi_n++;
            if (hi_n == stretch) tgt_hold = 1'b0;
            @(negedge clk);
        end
        tgt_hold = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 drive", int'(drv_a), 0);
        chk("R1 strobes", int'(seen_a | done_a | hold_a), 0);
    endtask

    task automatic t_std();
        int lo_n, hi_n;
        prep(2'b01);
        bit_pulse(1'b0, 0, lo_n, hi_n);
        chk("R2 low", lo_n, 24);
        chk("R2 high", hi_n, 21);
    endtask

    task automatic t_fast();
        int lo_n, hi_n;
        prep(2'b10);
        bit_pulse(1'b0, 0, lo_n, hi_n);
        chk("R3 low", lo_n, 11);
        chk("R3 high", hi_n, 10);
        prep(2'b00);
        bit_pulse(1'b0, 0, lo_n, hi_n);
        chk("R3 low code00", lo_n, 11);
    endtask

    task automatic t_hs();
        int lo_n, hi_n;
        prep(2'b11);
        bit_pulse(1'b0, 0, lo_n, hi_n);
        chk("R4 low", lo_n, 8);
        chk("R4 high", hi_n, 8);
    endtask

    task automatic t_fallback();
        int lo_n, hi_n;
        prep(2'b11);
        bit_pulse(1'b1, 0, lo_n, hi_n);
        chk("R5 low", lo_n, 11);
        chk("R5 high", hi_n, 10);
    endtask

    task automatic t_clamp();
        int lo_n, hi_n;
        enable = 1'b0;
        wr(3, 2);
        wr(2, 0);
        prep(2'b10);
        bit_pulse(1'b0, 0, lo_n, hi_n);
        chk("R6 low", lo_n, 6);
        chk("R6 high", hi_n, 7);
        enable = 1'b0;
        wr(3, 11);
        wr(2, 9);
    endtask

    task automatic t_stretch();
        int lo_n, hi_n;
        prep(2'b10);
        bit_pulse(1'b0, 5, lo_n, hi_n);
        chk("R7 low", lo_n, 11);
        chk("R7 released", hi_n, 14);
    endtask

    task automatic t_hold();
        int lo_n, hi_n, k;
        prep(2'b10);
        done_cnt = 0;
        bit_pulse(1'b0, 0, lo_n, hi_n);
        chk("R11 one done", done_cnt, 1);
        k = 0;
        while (!hold_a && k < 100) begin
            k++;
            @(negedge clk);
        end
        chk("R8 hold delay", k, 3);
        @(negedge clk);
        chk("R8 single", int'(hold_a), 0);
    endtask

    task automatic t_frozen();
        int lo_n, hi_n;
        prep(2'b01);
        wr(1, 30);
        bit_pulse(1'b0, 0, lo_n, hi_n);
        chk("R9 ignored write", lo_n, 24);
    endtask

    task automatic t_disable();
        int lo_n;
        prep(2'b01);
        @(negedge clk);
        step_req = 1'b1;
        @(negedge clk);
        step_req = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 low before", int'(drv_a), 1);
        enable = 1'b0;
        @(negedge clk);
        chk("R10 released", int'(drv_a), 0);
        enable = 1'b1;
        step_req = 1'b1;
        @(negedge clk);
        step_req = 1'b0;
        lo_n = 0;
        repeat (10) begin
            @(negedge clk);
            if (drv_a) lo_n++;
        end
        chk("R10 step in idle", lo_n, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        wr(0, 20); wr(1, 24);
        wr(2, 9);  wr(3, 11);
        wr(4, 7);  wr(5, 8);
        wr(6, 3);
        t_std();
        t_fast();
        t_hs();
        t_fallback();
        t_clamp();
        t_stretch();
        t_hold();
        t_frozen();
        t_disable();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule